// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a general-purpose I/O controller for 64 pins behind a simple 32-bit register bus with address, write enable, write data and combinational read data. Each pin has an output latch and a direction bit. The latch is never written directly. Software raises latch bits through a write-one-to-set register and lowers them through a write-one-to-clear register, so no read-modify-write is needed and concurrent users cannot disturb each other's pins.

Pin inputs are synchronised before use. The synchronised levels can be read back. They also feed per-pin edge detectors, each with its own rising-edge and falling-edge enable. Detected edges latch into a status register, which software clears by writing ones to it. A single interrupt line is asserted whenever any status bit is pending. Software scans the status words to find the pins that fired.

Top module: `gpio_ctrl`

## Requirements
- R1: Pin n lives in bit (n mod 32) of word (n / 32) of each register kind. The byte offsets of word 0 and word 1 are as follows: level 0x00/0x04, direction 0x08/0x0C, set 0x10/0x14, clear 0x18/0x1C, rising enable 0x20/0x24, falling enable 0x28/0x2C, status 0x30/0x34. All other offsets read as zero and ignore writes.
- R2: The level register returns the pin inputs after a two-flop synchroniser. A change on `pin_in` settled before a clock edge is first visible in the level read after the second rising edge.
- R3: Writing a 1 to a bit of the set register drives that pin's output latch (`pin_out`) high on the next edge. A 0 bit leaves the latch unchanged, and the latch changes only through set or clear writes. The set register reads as zero.
- R4: Writing a 1 to a bit of the clear register drives that pin's output latch low on the next edge. A 0 bit leaves the latch unchanged. The clear register reads as zero.
- R5: The direction register is plain read/write and appears on `pin_oe`. A 1 marks an output and a 0 marks an input.
- R6: When the rising enable of a pin is 1, a synchronised 0-to-1 transition sets its status bit. The bit becomes readable after the third rising edge following the input change. With the enable at 0, no rising edge sets the bit.
- R7: The falling enable does the same for 1-to-0 transitions. With both enables set, either edge sets the bit. With neither set, no edge does.
- R8: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R9: If a clearing write and a newly detected enabled edge hit the same status bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly while at least one status bit is set, across both words.
- R11: Synchronous active-high reset clears the latch, direction, both enables, the status bits and the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register word |
| we | input | 1 | Write strobe for the addressed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| pin_in | input | 64 | Asynchronous pin inputs |
| pin_out | output | 64 | Output latch per pin |
| pin_oe | output | 64 | Output enable per pin (direction) |
| irq | output | 1 | Combined pending-edge interrupt |

## Verification
The bench builds the block with its default parameters: 64 pins in 32-bit words and an 8-bit address. This gives two words per register kind, so the word-select logic, the bit mapping across the word boundary and the reduction of both status words into `irq` are all exercised. Sparse random toggling of pins under random enables produces single edges, double edges and edges that meet clearing writes. Directed sequences pin down the exact three-cycle detection latency and the collision case in which the edge takes priority over the clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register kinds; the numeric value is the block index in the address map
    typedef enum logic [2:0] {
        RK_LEVEL = 3'd0,
        RK_DIR   = 3'd1,
        RK_SET   = 3'd2,
        RK_CLR   = 3'd3,
        RK_RISE  = 3'd4,
        RK_FALL  = 3'd5,
        RK_STAT  = 3'd6,
        RK_NONE  = 3'd7
    } reg_kind_e;

    localparam int unsigned NUM_KINDS = 7;

    // Decoded bus access
    typedef struct packed {
        reg_kind_e kind;
        logic      wr;
    } bus_op_t;

    function automatic reg_kind_e kind_of(input int unsigned word_idx,
                                          input int unsigned words);
        int unsigned k;
        k = word_idx / words;
        if (k < NUM_KINDS) return reg_kind_e'(k[2:0]);
        return RK_NONE;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            meta   <= d;
            q      <= meta;
            q_prev <= q;
        end
    end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = (rise_en[i] &  cur[i] & ~prev[i])
                      | (fall_en[i] & ~cur[i] &  prev[i]);
    end

    // a fresh edge outranks a clearing write on the same bit
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_mask) | hit;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 64,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned WORDS   = NUM_PINS / DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WORDS-1:0]    word_we,
    input  reg_kind_e           kind,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] latch,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] rise_en,
    output logic [NUM_PINS-1:0] fall_en,
    output logic [NUM_PINS-1:0] stat_clr
);
    logic [NUM_PINS-1:0] lane_en;
    logic [NUM_PINS-1:0] wide;
    logic [NUM_PINS-1:0] set_m, clr_m, dir_m, rise_m, fall_m;

    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        assign lane_en[w*DATA_W +: DATA_W] = {DATA_W{word_we[w]}};
    end

    assign wide     = {WORDS{wdata}};
    assign set_m    = (kind == RK_SET)  ? (wide & lane_en) : '0;
    assign clr_m    = (kind == RK_CLR)  ? (wide & lane_en) : '0;
    assign stat_clr = (kind == RK_STAT) ? (wide & lane_en) : '0;
    assign dir_m    = (kind == RK_DIR)  ? lane_en : '0;
    assign rise_m   = (kind == RK_RISE) ? lane_en : '0;
    assign fall_m   = (kind == RK_FALL) ? lane_en : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch   <= '0;
            dir     <= '0;
            rise_en <= '0;
            fall_en <= '0;
        end else begin
            latch   <= (latch | set_m) & ~clr_m;
            dir     <= (dir     & ~dir_m)  | (wide & dir_m);
            rise_en <= (rise_en & ~rise_m) | (wide & rise_m);
            fall_en <= (fall_en & ~fall_m) | (wide & fall_m);
        end
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 64,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int unsigned WORDS    = NUM_PINS / DATA_W;
    localparam int unsigned BYTE_LSB = $clog2(DATA_W / 8);
    localparam int unsigned IDX_W    = ADDR_W - BYTE_LSB;

    logic [IDX_W-1:0]    word_idx;
    int unsigned         word_num;
    int unsigned         cur_word;
    bus_op_t             op;
    logic [WORDS-1:0]    word_we;

    logic [NUM_PINS-1:0] level, level_prev;
    logic [NUM_PINS-1:0] dir, rise_en, fall_en, stat_clr;
    logic [NUM_PINS-1:0] status_q;

    assign word_idx = addr[ADDR_W-1:BYTE_LSB];
    assign word_num = 32'(word_idx);
    assign cur_word = word_num % WORDS;
    assign op.kind  = kind_of(word_num, WORDS);
    assign op.wr    = we;

    for (genvar w = 0; w < WORDS; w++) begin : g_wsel
        assign word_we[w] = op.wr && (cur_word == w);
    end

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (pin_in),
        .q      (level),
        .q_prev (level_prev)
    );

    gpio_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .word_we  (word_we),
        .kind     (op.kind),
        .wdata    (wdata),
        .latch    (pin_out),
        .dir      (dir),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .stat_clr (stat_clr)
    );

    gpio_edge #(.W(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .cur      (level),
        .prev     (level_prev),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .clr_mask (stat_clr),
        .status   (status_q)
    );

    assign pin_oe = dir;
    assign irq    = |status_q;

    always_comb begin
        case (op.kind)
            RK_LEVEL: rdata = level   [cur_word*DATA_W +: DATA_W];
            RK_DIR:   rdata = dir     [cur_word*DATA_W +: DATA_W];
            RK_RISE:  rdata = rise_en [cur_word*DATA_W +: DATA_W];
            RK_FALL:  rdata = fall_en [cur_word*DATA_W +: DATA_W];
            RK_STAT:  rdata = status_q[cur_word*DATA_W +: DATA_W];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int unsigned NUM_PINS = 64,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr,
    input logic                we,
    input logic [DATA_W-1:0]   wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq
);
    localparam int unsigned WORDS = NUM_PINS / DATA_W;
    localparam int unsigned BLK   = WORDS * (DATA_W / 8);
    localparam logic [ADDR_W-1:0] A_DIR0  = ADDR_W'(1 * BLK);
    localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(2 * BLK);
    localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(3 * BLK);
    localparam logic [ADDR_W-1:0] A_RISE0 = ADDR_W'(4 * BLK);
    localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(6 * BLK);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(7 * BLK);

    logic latch_wr, stat_wr, rst_q;
    assign latch_wr = we && (addr >= A_SET0)  && (addr < A_RISE0);
    assign stat_wr  = we && (addr >= A_STAT0) && (addr < A_END);

    // R3
    set_word0_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_SET0) |=>
            pin_out[DATA_W-1:0] == ($past(pin_out[DATA_W-1:0]) | $past(wdata)));

    // R4
    clr_word0_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CLR0) |=>
            pin_out[DATA_W-1:0] == ($past(pin_out[DATA_W-1:0]) & ~$past(wdata)));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_wr |=> $stable(pin_out));

    // R5
    dir_word0_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_DIR0) |=> pin_oe[DATA_W-1:0] == $past(wdata));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_wr) |=> irq);

    always_ff @(posedge clk) rst_q <= rst;

    // R11
    always @(negedge clk) begin
        if (rst_q) begin
            reset_state_chk: assert (pin_out == '0 && pin_oe == '0 && !irq);
        end
    end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .we      (we),
    .wdata   (wdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_ctrl uut (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // spec model, updated on the same edges as the design
    logic [63:0] m_s1, m_s2, m_prev, m_lat, m_dir, m_re, m_fe, m_st;

    always @(posedge clk) begin : model
        logic [63:0] hit, wmask, stclr;
        int unsigned idx, k, w;
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_lat <= '0;
            m_dir <= '0; m_re <= '0; m_fe <= '0; m_st <= '0;
        end else begin
            hit   = (m_s2 & ~m_prev & m_re) | (~m_s2 & m_prev & m_fe);
            stclr = '0;
            if (we) begin
                idx   = 32'(addr) >> 2;
                k     = idx / 2;
                w     = idx % 2;
                wmask = 64'(32'hFFFF_FFFF) << (w * 32);
                case (k)
                    1: m_dir <= (m_dir & ~wmask) | ({2{wdata}} & wmask);
                    2: m_lat <= m_lat | ({2{wdata}} & wmask);
                    3: m_lat <= m_lat & ~({2{wdata}} & wmask);
                    4: m_re  <= (m_re & ~wmask) | ({2{wdata}} & wmask);
                    5: m_fe  <= (m_fe & ~wmask) | ({2{wdata}} & wmask);
                    6: stclr = {2{wdata}} & wmask;
                    default: ;
                endcase
            end
            m_st   <= (m_st & ~stclr) | hit;
            m_prev <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= pin_in;
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int unsigned idx, w;
        idx = 32'(a) >> 2;
        w   = idx % 2;
        case (idx / 2)
            0: return m_s2 [w*32 +: 32];
            1: return m_dir[w*32 +: 32];
            4: return m_re [w*32 +: 32];
            5: return m_fe [w*32 +: 32];
            6: return m_st [w*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a falling edge; stays in the low phase
    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        we = 1'b0;
        addr = a;
        #1;
        chk(req, 64'(rdata), 64'(exp));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 pin_out", pin_out, 64'h0);
        chk("R11 pin_oe", pin_oe, 64'h0);
        chk("R11 irq", 64'(irq), 64'h0);
        for (int i = 0; i < 14; i++) rd("R11 reg", 8'(i * 4), 32'h0);

        // R3 set, R1 mapping of pin 35 to word 1 bit 3
        wr(8'h10, 32'h0000_00F0);
        chk("R3 set word0", pin_out, 64'h0000_0000_0000_00F0);
        wr(8'h10, 32'h0);
        chk("R3 zero write", pin_out, 64'h0000_0000_0000_00F0);
        rd("R3 set reads zero", 8'h10, 32'h0);
        wr(8'h14, 32'h8);
        chk("R1 pin35 latch", 64'(pin_out[35]), 64'h1);

        // R4 clear
        wr(8'h18, 32'h30);
        chk("R4 clear word0", pin_out, 64'h0000_0008_0000_00C0);
        wr(8'h18, 32'h0);
        chk("R4 zero write", pin_out, 64'h0000_0008_0000_00C0);
        rd("R4 clear reads zero", 8'h18, 32'h0);

        // R5 direction
        wr(8'h08, 32'hA5A5_0000);
        wr(8'h0C, 32'h0000_1234);
        rd("R5 dir word0", 8'h08, 32'hA5A5_0000);
        rd("R5 dir word1", 8'h0C, 32'h0000_1234);
        chk("R5 pin_oe", pin_oe, 64'h0000_1234_A5A5_0000);

        // R2 synchroniser latency on pin 33
        pin_in[33] = 1'b1;
        @(negedge clk);
        rd("R2 after one edge", 8'h04, 32'h0);
        @(negedge clk);
        rd("R2 after two edges", 8'h04, 32'h2);

        // R6 rising edge on pin 40 (word 1 bit 8)
        wr(8'h24, 32'h100);
        pin_in[40] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd("R6 not yet", 8'h34, 32'h0);
        chk("R10 irq low", 64'(irq), 64'h0);
        @(negedge clk);
        rd("R6 rise detected", 8'h34, 32'h100);
        chk("R10 irq high", 64'(irq), 64'h1);
        // R7 falling edge with fall disabled
        pin_in[40] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 fall ignored", 64'(rdata), 64'h100);
        rd("R7 fall ignored rd", 8'h34, 32'h100);

        // R8 write-one-to-clear
        wr(8'h34, 32'h0);
        rd("R8 zero write", 8'h34, 32'h100);
        chk("R10 irq held", 64'(irq), 64'h1);
        wr(8'h34, 32'h100);
        rd("R8 cleared", 8'h34, 32'h0);
        chk("R10 irq dropped", 64'(irq), 64'h0);

        // R7 both edges on pin 5
        wr(8'h20, 32'h20);
        wr(8'h28, 32'h20);
        pin_in[5] = 1'b1;
        repeat (3) @(negedge clk);
        rd("R7 both rise", 8'h30, 32'h20);
        wr(8'h30, 32'h20);
        pin_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        rd("R7 both fall", 8'h30, 32'h20);
        wr(8'h30, 32'h20);
        rd("R8 clear again", 8'h30, 32'h0);

        // R9 clear collides with new edge
        pin_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(8'h30, 32'h20);
        rd("R9 edge wins", 8'h30, 32'h20);
        chk("R9 irq", 64'(irq), 64'h1);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            chk("R3 R4 pin_out", pin_out, m_lat);
            chk("R5 pin_oe", pin_oe, m_dir);
            chk("R10 irq", 64'(irq), 64'(|m_st));
            we    = ($urandom_range(0, 1) == 1);
            addr  = 8'($urandom_range(0, 15) * 4);
            wdata = $urandom & $urandom;
            pin_in = pin_in ^ ({$urandom, $urandom} & {$urandom, $urandom}
                               & {$urandom, $urandom});
            #1;
            if (!we) chk("R1 R2 R6 R8 read", 64'(rdata), 64'(exp_read(addr)));
            @(negedge clk);
        end
        we = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule